// File: doc/BRIEF.md
# Asynchronous SRAM Controller

This block lets a clocked host read and write a 32768-word by 8-bit asynchronous static RAM. The host hands over one request at a time: an address, a write flag and write data. The controller turns each request into a correctly timed sequence on the memory's active-low select, output-enable and write-strobe lines, its 15-bit address bus and its split 8-bit data bus (drive value, drive enable and sampled input). All memory timing comes from nanosecond minima and the clock period, given as parameters. The controller rounds each one up to whole clock cycles, with a floor of one cycle.

Writes are ended by the write strobe while select stays low, so data setup and hold are measured from the strobe's rising edge. The output enable stays high for the whole write. The controller drives the data bus only after the strobe is low, and releases it one cycle after the strobe rises. A read keeps select and output enable low for the access count and samples the bus at the last edge. Select and output enable then stay high for a turnaround window, so the memory's drivers are off before the controller can drive again. When no request is in flight, the memory is deselected and enters its low-power standby.

The request side is valid/ready. The host raises `req_valid` and holds the request fields steady until a rising clock edge sees `req_valid` and `req_ready` both high. `req_ready` is high only in idle, so the controller applies back-pressure for the whole length of every transfer. The response is a one-cycle `rsp_valid` pulse with no back-pressure, and the host must take it in that cycle.

Top module: `asram_ctl`

## Requirements
- R1: `req_ready` is high only while no transfer is in progress. A request is taken at a rising edge with `req_valid` and `req_ready` both high. Address, data and write flag are sampled there, and later changes on those inputs have no effect on the transfer.
- R2: Out of reset and whenever idle, `sram_ce_n`, `sram_we_n` and `sram_oe_n` are 1 and `sram_dq_oe` is 0.
- R3: A write drives the address and pulls `sram_ce_n` low at the accept edge. It pulls `sram_we_n` low one cycle later. `sram_oe_n` stays 1 while `sram_we_n` is 0, and `sram_we_n` is never 0 while `sram_ce_n` is 1.
- R4: Write data is driven only from the second cycle of the strobe-low window and stays unchanged while driven. It is valid at least the data-setup time before `sram_we_n` rises, and the strobe stays low for 1 + max(setup cycles, pulse cycles - 1) cycles, which is 4 cycles at defaults.
- R5: After `sram_we_n` rises with select low, the data stays driven for one more cycle. The next edge releases the bus and raises `sram_ce_n`. A write's `rsp_valid` appears 7 cycles after the accept edge at defaults.
- R6: A read holds `sram_ce_n` and `sram_oe_n` low with `sram_we_n` high for the access count (4 cycles at defaults). The controller samples `sram_dq_i` at the last edge of that window and presents it on `rsp_rdata`, together with `rsp_valid`, 5 cycles after accept.
- R7: After a read, `sram_ce_n` and `sram_oe_n` stay high for the turnaround count (2 cycles at defaults) before `req_ready` returns. `sram_dq_oe` is never 1 while `sram_oe_n` is 0 or in the cycle right after it was 0, and the controller never drives while the memory's outputs are on.
- R8: `rsp_valid` is a one-cycle pulse for each accepted request. `rsp_rdata` holds the last read value until the next read completes.
- R9: `sram_addr` does not change while `sram_ce_n` stays low.
- R10: Data read from any address, including 0 and 0x7FFF, equals the last data written there.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 15 | Word address |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Last read data |
| sram_ce_n | output | 1 | Memory select, active low |
| sram_oe_n | output | 1 | Memory output enable, active low |
| sram_we_n | output | 1 | Memory write strobe, active low |
| sram_addr | output | 15 | Memory address |
| sram_dq_o | output | 8 | Data driven toward the memory |
| sram_dq_oe | output | 1 | Drive enable for `sram_dq_o` |
| sram_dq_i | input | 8 | Data seen on the memory bus |

## Verification
The hardest cases to reach from the ports are data that arrives just barely late and bus turnaround that is one cycle short, because a memory that answers instantly hides both. The bench's memory model checks the real time between the last change on the drive lines and the strobe's rising edge. It also checks the strobe's low width and the time since output enable rose. Until 15 ns after select, output enable or address last changed, the model returns the inverse of the stored byte, so a sample taken one cycle early shows up as wrong read data. Random writes followed by read-back then exercise these windows across the address range.

// File: rtl/asram_ctl_pkg.sv
`timescale 1ns/1ps
package asram_ctl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_ACC,
    ST_RD_TURN,
    ST_WR_ADDR,
    ST_WR_ARM,
    ST_WR_DATA,
    ST_WR_HOLD
  } st_e;

  typedef struct packed {
    logic ce_n;
    logic oe_n;
    logic we_n;
    logic dq_en;
  } pins_t;

  // Pin levels belonging to each sequencer state
  function automatic pins_t pins_of(st_e s);
    pins_t p;
    p = '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, dq_en: 1'b0};
    case (s)
      ST_RD_ACC:  begin p.ce_n = 1'b0; p.oe_n = 1'b0; end
      ST_WR_ADDR: p.ce_n = 1'b0;
      ST_WR_ARM:  begin p.ce_n = 1'b0; p.we_n = 1'b0; end
      ST_WR_DATA: begin p.ce_n = 1'b0; p.we_n = 1'b0; p.dq_en = 1'b1; end
      ST_WR_HOLD: begin p.ce_n = 1'b0; p.dq_en = 1'b1; end
      default:    p = '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, dq_en: 1'b0};
    endcase
    return p;
  endfunction

  // Round a picosecond minimum up to clock cycles, never below one
  function automatic int ps_to_cyc(int t_ps, int clk_ps);
    int c;
    c = (t_ps + clk_ps - 1) / clk_ps;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(int a, int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/asram_cnt.sv
`timescale 1ns/1ps
module asram_cnt #(
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          at_zero
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= load_val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign at_zero = (cnt_q == '0);
endmodule

// File: rtl/asram_hold.sv
`timescale 1ns/1ps
module asram_hold #(
  parameter int AW = 15,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic          cap_rd,
  input  logic [DW-1:0] dq_in,
  output logic [AW-1:0] addr_q,
  output logic [DW-1:0] wdata_q,
  output logic [DW-1:0] rdata_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (take) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_q <= '0;
    else if (cap_rd) rdata_q <= dq_in;
  end
endmodule

// File: rtl/asram_fsm.sv
`timescale 1ns/1ps
module asram_fsm
  import asram_ctl_pkg::*;
#(
  parameter int CW       = 3,
  parameter int RD_CYC   = 4,
  parameter int WD_CYC   = 3,
  parameter int TURN_CYC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  output logic          req_ready,
  output logic          take,
  output logic          cap_rd,
  output logic          done,
  output pins_t         pins,
  output logic          cnt_load,
  output logic [CW-1:0] cnt_val,
  input  logic          cnt_zero
);
  localparam logic [CW-1:0] RD_LD   = CW'(RD_CYC - 1);
  localparam logic [CW-1:0] WD_LD   = CW'(WD_CYC - 1);
  localparam logic [CW-1:0] TURN_LD = CW'(TURN_CYC - 1);

  st_e  st_q, st_d;
  logic done_d;

  always_comb begin
    st_d     = st_q;
    take     = 1'b0;
    cap_rd   = 1'b0;
    done_d   = 1'b0;
    cnt_load = 1'b0;
    cnt_val  = '0;
    case (st_q)
      ST_IDLE: if (req_valid) begin
        take = 1'b1;
        if (req_write) st_d = ST_WR_ADDR;
        else begin
          st_d     = ST_RD_ACC;
          cnt_load = 1'b1;
          cnt_val  = RD_LD;
        end
      end
      ST_RD_ACC: if (cnt_zero) begin
        cap_rd   = 1'b1;
        done_d   = 1'b1;
        st_d     = ST_RD_TURN;
        cnt_load = 1'b1;
        cnt_val  = TURN_LD;
      end
      ST_RD_TURN: if (cnt_zero) st_d = ST_IDLE;
      ST_WR_ADDR: st_d = ST_WR_ARM;
      ST_WR_ARM: begin
        st_d     = ST_WR_DATA;
        cnt_load = 1'b1;
        cnt_val  = WD_LD;
      end
      ST_WR_DATA: if (cnt_zero) st_d = ST_WR_HOLD;
      ST_WR_HOLD: begin
        st_d   = ST_IDLE;
        done_d = 1'b1;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // Pins are registered from the next state so they never glitch
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
      pins <= pins_of(ST_IDLE);
      done <= 1'b0;
    end else begin
      st_q <= st_d;
      pins <= pins_of(st_d);
      done <= done_d;
    end
  end

  assign req_ready = (st_q == ST_IDLE);
endmodule

// File: rtl/asram_ctl.sv
`timescale 1ns/1ps
module asram_ctl
  import asram_ctl_pkg::*;
#(
  parameter int ADDR_W    = 15,
  parameter int DATA_W    = 8,
  parameter int CLK_PS    = 4000,
  parameter int T_PWE_PS  = 9000,
  parameter int T_SD_PS   = 9000,
  parameter int T_AA_PS   = 15000,
  parameter int T_OHZ_PS  = 7000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              sram_ce_n,
  output logic              sram_oe_n,
  output logic              sram_we_n,
  output logic [ADDR_W-1:0] sram_addr,
  output logic [DATA_W-1:0] sram_dq_o,
  output logic              sram_dq_oe,
  input  logic [DATA_W-1:0] sram_dq_i
);
  localparam int PWE_CYC  = ps_to_cyc(T_PWE_PS, CLK_PS);
  localparam int SD_CYC   = ps_to_cyc(T_SD_PS, CLK_PS);
  localparam int RD_CYC   = ps_to_cyc(T_AA_PS, CLK_PS);
  localparam int TURN_CYC = ps_to_cyc(T_OHZ_PS, CLK_PS);
  localparam int WD_CYC   = imax(SD_CYC, imax(PWE_CYC - 1, 1));
  localparam int MAX_CYC  = imax(RD_CYC, imax(WD_CYC, TURN_CYC));
  localparam int CW       = $clog2(MAX_CYC + 1);

  logic          take, cap_rd, cnt_load, cnt_zero;
  logic [CW-1:0] cnt_val;
  pins_t         pins;

  asram_fsm #(
    .CW(CW), .RD_CYC(RD_CYC), .WD_CYC(WD_CYC), .TURN_CYC(TURN_CYC)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write), .req_ready(req_ready),
    .take(take), .cap_rd(cap_rd), .done(rsp_valid), .pins(pins),
    .cnt_load(cnt_load), .cnt_val(cnt_val), .cnt_zero(cnt_zero)
  );

  asram_cnt #(.CW(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n),
    .load(cnt_load), .load_val(cnt_val), .at_zero(cnt_zero)
  );

  asram_hold #(.AW(ADDR_W), .DW(DATA_W)) u_hold (
    .clk(clk), .rst_n(rst_n),
    .take(take), .req_addr(req_addr), .req_wdata(req_wdata),
    .cap_rd(cap_rd), .dq_in(sram_dq_i),
    .addr_q(sram_addr), .wdata_q(sram_dq_o), .rdata_q(rsp_rdata)
  );

  assign sram_ce_n  = pins.ce_n;
  assign sram_oe_n  = pins.oe_n;
  assign sram_we_n  = pins.we_n;
  assign sram_dq_oe = pins.dq_en;
endmodule

// File: rtl/asram_ctl_chk.sv
`timescale 1ns/1ps
module asram_ctl_chk #(
  parameter int AW = 15,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_ready,
  input logic          rsp_valid,
  input logic          sram_ce_n,
  input logic          sram_oe_n,
  input logic          sram_we_n,
  input logic [AW-1:0] sram_addr,
  input logic [DW-1:0] sram_dq_o,
  input logic          sram_dq_oe
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (sram_ce_n && sram_we_n && sram_oe_n && !sram_dq_oe)); // R2
  AST_WE_UNDER_CE: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_we_n |-> !sram_ce_n); // R3
  AST_OE_OFF_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_we_n |-> sram_oe_n); // R3
  AST_DRIVE_AFTER_WE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_dq_oe) |-> $past(!sram_we_n)); // R4
  AST_WDATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (sram_dq_oe && $past(sram_dq_oe)) |-> $stable(sram_dq_o)); // R4
  AST_HOLD_AFTER_WE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_we_n) |-> sram_dq_oe); // R5
  AST_RELEASE_DESEL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_we_n) |=> (!sram_dq_oe && sram_ce_n)); // R5
  AST_NO_FIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    sram_dq_oe |-> (sram_oe_n && $past(sram_oe_n))); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R8
  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!sram_ce_n && $past(!sram_ce_n)) |-> $stable(sram_addr)); // R9
endmodule

bind asram_ctl asram_ctl_chk #(.AW(ADDR_W), .DW(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .sram_ce_n(sram_ce_n), .sram_oe_n(sram_oe_n), .sram_we_n(sram_we_n),
  .sram_addr(sram_addr), .sram_dq_o(sram_dq_o), .sram_dq_oe(sram_dq_oe)
);

// File: tb/asram_ctl_test.sv
`timescale 1ns/1ps
module asram_ctl_test;
  localparam int CLK_PS = 4000;
  localparam int PWE  = (9000 + CLK_PS - 1) / CLK_PS;
  localparam int SD   = (9000 + CLK_PS - 1) / CLK_PS;
  localparam int AA   = (15000 + CLK_PS - 1) / CLK_PS;
  localparam int TURN = (7000 + CLK_PS - 1) / CLK_PS;
  localparam int EXP_WE_LOW = 1 + ((SD > PWE - 1) ? SD : PWE - 1);
  localparam int EXP_WR_LAT = EXP_WE_LOW + 3;
  localparam int EXP_RD_LAT = AA + 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [14:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic req_ready, rsp_valid, sram_ce_n, sram_oe_n, sram_we_n, sram_dq_oe;
  logic [7:0]  rsp_rdata, sram_dq_o;
  logic [14:0] sram_addr;
  logic [7:0]  mdl_dq = 8'h00;

  int checks = 0, bad = 0;
  int viol_setup = 0, viol_pwe = 0, viol_fight = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  asram_ctl uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .sram_ce_n(sram_ce_n), .sram_oe_n(sram_oe_n), .sram_we_n(sram_we_n),
    .sram_addr(sram_addr), .sram_dq_o(sram_dq_o), .sram_dq_oe(sram_dq_oe),
    .sram_dq_i(mdl_dq)
  );

  // ---------------- behavioural memory model ----------------
  logic [7:0] mem [int];
  logic [7:0] exp_mem [int];
  realtime t_ctl = 0.0, t_dq = 0.0, t_we_fall = 0.0, t_oe_rise = -100.0;

  function automatic logic [7:0] mem_rd(int a);
    return mem.exists(a) ? mem[a] : 8'hA5;
  endfunction

  always @(sram_ce_n or sram_oe_n or sram_we_n or sram_addr) t_ctl = $realtime;
  always @(sram_dq_o or sram_dq_oe) t_dq = $realtime;
  always @(negedge sram_we_n) t_we_fall = $realtime;
  always @(posedge sram_oe_n) t_oe_rise = $realtime;

  always @(posedge sram_we_n) if (!sram_ce_n) begin
    if (!sram_dq_oe || ($realtime - t_dq) < 9.0) begin
      viol_setup++;
      $display("model: data setup short at %0t", $realtime);
    end
    if (($realtime - t_we_fall) < 9.0) begin
      viol_pwe++;
      $display("model: strobe too short at %0t", $realtime);
    end
    mem[int'(sram_addr)] = sram_dq_o;
  end

  initial begin
    #0.125;
    forever begin
      automatic logic drv = !sram_ce_n && !sram_oe_n && sram_we_n;
      automatic logic [7:0] v = mem_rd(int'(sram_addr));
      mdl_dq = (drv && ($realtime - t_ctl) >= 15.0) ? v : ~v;
      if (sram_dq_oe && (drv || ($realtime - t_oe_rise) < 7.0)) viol_fight++;
      #0.25;
    end
  end

  // strobe / output-enable low-run measurement at negedges
  int we_run = 0, we_len = 0, oe_run = 0, oe_len = 0;
  always @(negedge clk) begin
    if (!sram_we_n) we_run++;
    else if (we_run != 0) begin we_len = we_run; we_run = 0; end
    if (!sram_oe_n) oe_run++;
    else if (oe_run != 0) begin oe_len = oe_run; oe_run = 0; end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // ---------------- host side ----------------
  task automatic host_req(input bit wr, input logic [14:0] a, input logic [7:0] d,
                          output int lat, output bit busy_ok);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    #0.5;
    req_valid = 1'b0; req_addr = ~a; req_wdata = ~d; req_write = ~wr;
    lat = 0;
    busy_ok = 1'b1;
    do begin
      @(negedge clk);
      lat++;
      if (req_ready && !rsp_valid) busy_ok = 1'b0;
    end while (!rsp_valid && lat < 100);
  endtask

  task automatic do_write(input logic [14:0] a, input logic [7:0] d, output int lat);
    bit b;
    host_req(1'b1, a, d, lat, b);
    chk(b, "R1 ready low while writing", b, 1);
    exp_mem[int'(a)] = d;
  endtask

  task automatic do_read(input logic [14:0] a, output logic [7:0] q,
                         output int lat, output int turn, output bit pulse_ok);
    bit b;
    host_req(1'b0, a, 8'h00, lat, b);
    chk(b, "R1 ready low while reading", b, 1);
    q = rsp_rdata;
    turn = 0;
    pulse_ok = 1'b1;
    do begin
      @(negedge clk);
      turn++;
      if (rsp_valid) pulse_ok = 1'b0;
    end while (!req_ready && turn < 100);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    chk(sram_ce_n && sram_we_n && sram_oe_n && !sram_dq_oe, "R2 idle pins after reset",
        {sram_ce_n, sram_we_n, sram_oe_n, sram_dq_oe}, 4'b1110);
    chk(req_ready && !rsp_valid, "R2 ready/valid after reset", {req_ready, rsp_valid}, 2'b10);
  endtask

  task automatic t_write_read();
    int lat, turn; logic [7:0] q; bit p;
    do_write(15'h1234, 8'h3C, lat);
    chk(lat == EXP_WR_LAT, "R5 write completion latency", lat, EXP_WR_LAT);
    chk(we_len == EXP_WE_LOW, "R4 strobe low cycles", we_len, EXP_WE_LOW);
    chk(sram_ce_n && !sram_dq_oe, "R2 deselected after write", {sram_ce_n, sram_dq_oe}, 2'b10);
    do_read(15'h1234, q, lat, turn, p);
    chk(q == 8'h3C, "R6 read data", q, 8'h3C);
    chk(lat == EXP_RD_LAT, "R6 read completion latency", lat, EXP_RD_LAT);
    chk(oe_len == AA, "R6 output enable low cycles", oe_len, AA);
    chk(turn == TURN, "R7 turnaround before ready", turn, TURN);
    chk(p, "R8 single-cycle done pulse", p, 1);
  endtask

  task automatic t_ignore_after_accept();
    int lat, turn; logic [7:0] q; bit p;
    // host_req flips address/data right after acceptance
    do_write(15'h0400, 8'h96, lat);
    do_read(15'h0400, q, lat, turn, p);
    chk(q == 8'h96, "R1 post-accept input change ignored", q, 8'h96);
    do_read(~15'h0400, q, lat, turn, p);
    chk(q == 8'hA5, "R1 flipped address untouched", q, 8'hA5);
  endtask

  task automatic t_corners();
    int lat, turn; logic [7:0] q; bit p;
    do_write(15'h0000, 8'h11, lat);
    do_write(15'h7FFF, 8'hEE, lat);
    do_read(15'h0000, q, lat, turn, p);
    chk(q == 8'h11, "R10 address 0", q, 8'h11);
    do_read(15'h7FFF, q, lat, turn, p);
    chk(q == 8'hEE, "R10 address 0x7FFF", q, 8'hEE);
    do_write(15'h0001, 8'h77, lat);
    chk(rsp_rdata == 8'hEE, "R8 read data held across write", rsp_rdata, 8'hEE);
  endtask

  task automatic t_random();
    int lat, turn; logic [7:0] q; bit p; int errs = 0;
    for (int i = 0; i < 24; i++) begin
      automatic logic [14:0] a = 15'((i * 1237 + 91) & 32'h7FFF);
      do_write(a, 8'($urandom), lat);
    end
    for (int i = 23; i >= 0; i--) begin
      automatic logic [14:0] a = 15'((i * 1237 + 91) & 32'h7FFF);
      do_read(a, q, lat, turn, p);
      if (q !== exp_mem[int'(a)]) begin
        errs++;
        chk(1'b0, "R10 random read-back", q, exp_mem[int'(a)]);
      end
    end
    chk(errs == 0, "R10 random read-back summary", errs, 0);
  endtask

  task automatic t_model();
    chk(viol_setup == 0, "R4 data setup to strobe rise", viol_setup, 0);
    chk(viol_pwe == 0, "R4 strobe pulse width", viol_pwe, 0);
    chk(viol_fight == 0, "R7 bus contention", viol_fight, 0);
  endtask

  initial begin
    #800000;
    if (!finished) begin
      bad++;
      checks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_write_read();
    t_ignore_after_accept();
    t_corners();
    t_random();
    t_model();
    finished = 1;
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule